// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a combinational integer datapath for signal-processing code. It clamps 64-bit values into signed or unsigned 8-, 16- and 32-bit ranges. It also performs a 64-bit signed add that saturates instead of wrapping, and it applies four rounding and clipping rules. An operation code chosen per cycle selects which rule drives the 64-bit result.

Every clamp that actually changes a value is a saturation event. The events of all saturating operations feed a single sticky overflow bit. That bit is registered. It is set only on a clock edge where the input is marked valid, and it stays set until a synchronous clear is applied. Software-style flag mapping, pipelining and multiplication are outside this block.

Top module: `sat_alu`

## Requirements
- R1: Codes 0, 1 and 2 saturate `a` as a signed value to 8, 16 and 32 bits. A value that lies in the range passes through. Otherwise a negative value gives -(2^(N-1)) and a non-negative value gives 2^(N-1)-1. The result is sign-extended to 64 bits.
- R2: Codes 3, 4 and 5 saturate `a` as an unsigned value to 8, 16 and 32 bits. A value below 2^N passes through. Otherwise a negative value (bit 63 set) gives 0 and any other value gives 2^N-1.
- R3: Code 6 returns `a`+`b` as signed 64-bit numbers. When the operands have the same sign and the wrapped sum has the other sign, the result is 0x7FFF_FFFF_FFFF_FFFF if the wrapped sum is negative and 0x8000_0000_0000_0000 if it is not. That case is a saturation event.
- R4: Code 7 returns (`a`+1) shifted right arithmetically by one. The sum is formed exactly, without wrapping.
- R5: Code 8 returns `a`+1 (modulo 2^64) when `a[1:0]` is 2'b11, and returns `a` unchanged otherwise.
- R6: Code 9 sign-extends `a[31:0]` and limits it to [-(2^U), 2^U-1], where U is `clip_u` (0 to 31).
- R7: Code 10 returns `a[31:0]` sign-extended to 64 bits plus 2^(N-1), where N is `clip_u`. When N is 0 it returns the sign-extended value unchanged.
- R8: A saturation event under codes 0 to 6 sets `ovf` at the clock edge, but only while `in_valid` is high. Once set, `ovf` stays set. Codes 7 to 10 never set it.
- R9: `ovf_clr` clears `ovf` at the next clock edge. The clear wins over a simultaneous set.
- R10: Codes 11 to 15 give a result of 0 and leave `ovf` unchanged.
- R11: While `rst_n` is low, `ovf` is 0.
- R12: While `in_valid` is low, a saturating input leaves `ovf` unchanged. The result is still computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the operands valid; gates updates to the flag |
| ovf_clr | input | 1 | Synchronous clear of the sticky flag |
| op | input | 4 | Operation code |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B (used by the add) |
| clip_u | input | 5 | Clip width U, or round position N |
| result | output | 64 | Combinational result |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is an edge where a saturation event and a clear arrive together. Only the clear may take effect, and `ovf` must be 0 after that edge even though the result in the same cycle is clamped. The stimulus first sets the flag. It then drives an out-of-range add with the clear held high, then an invalid saturating cycle, and only then a valid one. These steps show separately that the flag sets, that the clear wins, and that the flag is gated by `in_valid`. Random operands over all codes cover the in-range and out-of-range boundaries of each width.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DW = 64,
  parameter int UW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          ovf_clr,
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [UW-1:0] clip_u,
  output logic [DW-1:0] result,
  output logic          ovf
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW:0] sat_s(input logic [DW-1:0] v, input int n);
    logic signed [DW-1:0] top;
    logic [DW-1:0] pos;
    top = $signed(v) >>> (n - 1);
    pos = (ONE << (n - 1)) - ONE;
    if (top == '0 || top == '1) return {1'b0, v};
    return {1'b1, v[DW-1] ? ~pos : pos};
  endfunction

  function automatic logic [DW:0] sat_u(input logic [DW-1:0] v, input int n);
    if ((v >> n) == '0) return {1'b0, v};
    return {1'b1, v[DW-1] ? '0 : (ONE << n) - ONE};
  endfunction

  logic [DW-1:0] sum, low_sx, half_sum, cmax;
  logic [DW:0]   sat_res;
  logic          add_ovf, sat_ev;

  assign sum     = a + b;
  assign add_ovf = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
  assign low_sx  = {{(DW-32){a[31]}}, a[31:0]};
  assign cmax    = (ONE << clip_u) - ONE;

  logic [DW:0] a_ext;
  assign a_ext    = {a[DW-1], a} + {{DW{1'b0}}, 1'b1};
  assign half_sum = a_ext[DW:1];

  always_comb begin
    sat_res = '0;
    case (op)
      4'd0: sat_res = sat_s(a, 8);
      4'd1: sat_res = sat_s(a, 16);
      4'd2: sat_res = sat_s(a, 32);
      4'd3: sat_res = sat_u(a, 8);
      4'd4: sat_res = sat_u(a, 16);
      4'd5: sat_res = sat_u(a, 32);
      4'd6: sat_res = add_ovf ? {1'b1, sum[DW-1] ? SMAX : SMIN} : {1'b0, sum};
      4'd7: sat_res = {1'b0, half_sum};
      4'd8: sat_res = {1'b0, (a[1:0] == 2'b11) ? a + ONE : a};
      4'd9: begin
        if ($signed(low_sx) > $signed(cmax))       sat_res = {1'b0, cmax};
        else if ($signed(low_sx) < $signed(~cmax)) sat_res = {1'b0, ~cmax};
        else                                       sat_res = {1'b0, low_sx};
      end
      4'd10: sat_res = {1'b0, (clip_u == '0) ? low_sx
                                  : low_sx + (ONE << (clip_u - UW'(1)))};
      default: sat_res = '0;
    endcase
  end

  assign result = sat_res[DW-1:0];
  assign sat_ev = sat_res[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf <= 1'b0;
    else if (ovf_clr)           ovf <= 1'b0;
    else if (in_valid && sat_ev) ovf <= 1'b1;
  end
endmodule

module sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        ovf_clr,
  input logic [3:0]  op,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic [4:0]  clip_u,
  input logic [63:0] result,
  input logic        ovf
);
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf);
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd10) |-> (result == 64'd0));
  a_r10_undef_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd10 && !ovf_clr) |=> $stable(ovf));
  a_r12_idle_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !ovf_clr) |=> $stable(ovf));
  a_r3_mixed_sign_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6 && a[63] != b[63]) |-> (result == a + b));
  a_r8_set_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(in_valid && op <= 4'd6));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

bind sat_alu sat_alu_chk u_sat_alu_chk (.*);

// File: tb/test_sat_alu.sv
module test_sat_alu;
  logic clk = 0, rst_n = 0, in_valid = 0, ovf_clr = 0;
  logic [3:0] op = 0;
  logic [63:0] a = 0, b = 0;
  logic [4:0] clip_u = 0;
  logic [63:0] result;
  logic ovf;

  always #5 clk = ~clk;

  sat_alu i_sat_alu (.clk, .rst_n, .in_valid, .ovf_clr, .op, .a, .b, .clip_u, .result, .ovf);

  typedef struct { logic [63:0] res; logic ovf; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  logic model_ovf = 0;
  bit done = 0;

  function automatic void model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                                input logic [4:0] u, output logic [63:0] r, output logic ev);
    longint v, hi, lo, s32;
    logic signed [64:0] s;
    int n;
    v = $signed(x); ev = 0; r = 0;
    s32 = longint'($signed(x[31:0]));
    case (o)
      0, 1, 2: begin
        n = 8 << o;
        hi = (64'sd1 <<< (n-1)) - 1; lo = -hi - 1;
        if (v > hi) begin r = hi; ev = 1; end
        else if (v < lo) begin r = lo; ev = 1; end
        else r = x;
      end
      3, 4, 5: begin
        n = 8 << (o - 3);
        if (v < 0) begin r = 0; ev = 1; end
        else if (x >= (64'd1 << n)) begin r = (64'd1 << n) - 1; ev = 1; end
        else r = x;
      end
      6: begin
        s = 65'($signed(x)) + 65'($signed(y));
        if (s > 65'sh0_7FFF_FFFF_FFFF_FFFF) begin r = 64'h7FFF_FFFF_FFFF_FFFF; ev = 1; end
        else if (s < -65'sh0_8000_0000_0000_0000) begin r = 64'h8000_0000_0000_0000; ev = 1; end
        else r = s[63:0];
      end
      7: begin s = 65'($signed(x)) + 65'sd1; r = s[64:1]; end
      8: r = (x[1:0] == 2'b11) ? x + 1 : x;
      9: begin
        hi = (64'sd1 <<< u) - 1; lo = -hi - 1;
        r = (s32 > hi) ? hi : (s32 < lo) ? lo : s32;
      end
      10: r = (u == 0) ? s32 : s32 + (64'sd1 <<< (u - 1));
      default: r = 0;
    endcase
  endfunction

  task automatic step(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                      input logic [4:0] u, input logic v, input logic c, input string tag);
    exp_t e;
    logic ev;
    @(negedge clk);
    op = o; a = x; b = y; clip_u = u; in_valid = v; ovf_clr = c;
    model(o, x, y, u, e.res, ev);
    if (c) model_ovf = 0; else if (v && ev) model_ovf = 1;
    e.ovf = model_ovf; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (result !== e.res || ovf !== e.ovf) begin
          fails++;
          $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", e.tag, result, ovf, e.res, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (ovf !== 1'b0) begin fails++; $display("FAIL R11: ovf=%b expected 0", ovf); end
    rst_n = 1;
    step(0, 64'd127, 0, 0, 1, 0, "R1 s8 in range");
    step(1, 64'hFFFF_FFFF_FFFF_8000, 0, 0, 1, 0, "R1 s16 min in range");
    tests++;
    if (ovf !== 1'b0) begin fails++; $display("FAIL R11: ovf=%b expected 0 after reset", ovf); end
    step(6, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 1, 0, "R3 mixed sign");
    step(10, 64'd100, 0, 0, 1, 0, "R7 N=0");
    step(7, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 1, 0, "R4 max");
    step(9, 64'h0000_0000_8000_0000, 0, 5'd31, 1, 0, "R6 U=31 min");
    step(12, 64'hFFFF, 64'h1, 0, 1, 0, "R10 undef code");
    step(0, 64'd128, 0, 0, 0, 0, "R12 invalid no set");
    step(0, 64'd128, 0, 0, 1, 0, "R8 s8 overflow sets");
    step(8, 64'd3, 0, 0, 1, 0, "R8 sticky stays");
    step(15, 64'd0, 0, 0, 1, 0, "R10 flag held");
    step(6, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 1, "R9 clear beats set");
    step(6, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R12 neg add invalid");
    step(6, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, "R3 neg overflow");
    step(3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 1, "R2 negative to zero");
    step(5, 64'h1_0000_0000, 0, 0, 1, 0, "R2 u32 over");
    step(4, 64'hFFFF, 0, 0, 1, 1, "R2 u16 edge");
    step(2, 64'hFFFF_FFFF_7FFF_FFFF, 0, 0, 1, 0, "R1 s32 under");
    step(8, 64'd6, 0, 0, 1, 1, "R5 no round");
    step(8, 64'd7, 0, 0, 1, 0, "R5 round");
    step(7, 64'hFFFF_FFFF_FFFF_FFFD, 0, 0, 1, 0, "R4 negative");
    step(9, 64'd40, 0, 5'd4, 1, 0, "R6 clip high");
    step(9, 64'hFFFF_FFFF_FFFF_FFD0, 0, 5'd4, 1, 0, "R6 clip low");
    step(10, 64'hFFFF_FFFF_0000_0005, 0, 5'd3, 1, 0, "R7 N=3");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 3 == 0) x = 64'($signed(x[19:0]));
      step(4'($urandom_range(0, 15)), x, y, 5'($urandom), 1'($urandom), (i % 17) == 0,
           "R8 random mix");
    end
    @(negedge clk); in_valid = 0; ovf_clr = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule